// File: doc/BRIEF.md
# Crossbar Bid Retry Controller

This block sits in a first-stage module of a three-stage switch fabric and runs the bidding toward the centre-stage crossbars. It has one lane per crossbar. The lanes are identical and run independently. Each lane holds at most one outstanding bid. A bid names a destination, a service priority and the local queue the cell came from. The lane acts on the crossbar's answer once per time slot, and a slot strobe marks the slot boundary.

Each answer leads to one of three outcomes. A granted bid makes the lane send that cell in the next slot, and in the same slot the lane takes a fresh candidate from the queue selector. A bid that lost on crossbar contention is offered again unchanged. A bid refused by output backpressure is dropped. The lane then tells the selector which queue to skip and takes a different candidate. When the selector has nothing eligible, the lane stays idle and issues no bid.

Top module: `bid_ctrl_top`

## Requirements
- R1: While reset is asserted and right after it, no lane has a bid outstanding, transmits, takes a candidate or raises an exclusion.
- R2: Lane state and all registered outputs change only at a clock edge where `slot_stb` is high. With the strobe low, every input is ignored.
- R3: An idle lane that sees `cand_valid` at a strobe raises `cand_take` in that cycle. From the next cycle it bids with that candidate's queue index, destination and priority.
- R4: An idle lane that sees no valid candidate at a strobe takes nothing and stays without a bid.
- R5: Feedback code 2'b01 (grant) on an outstanding bid raises `tx_en` for the following slot, with `tx_qidx` set to the granted queue index. At the same strobe the lane takes a new candidate if one is valid, or goes idle.
- R6: Feedback code 2'b10 (lost to contention) keeps the bid fields unchanged for the next slot. The lane takes no candidate and does not transmit.
- R7: Feedback code 2'b11 (lost to backpressure) pulses `excl_vld` in the strobe cycle with `excl_idx` equal to the refused queue index. The lane takes a new candidate if one is valid, or goes idle, and does not transmit.
- R8: Feedback arriving while a lane has no bid outstanding has no effect. The lane does not transmit in the next slot.
- R9: Feedback code 2'b00 (no answer) on an outstanding bid keeps the bid unchanged and causes no transmission.
- R10: `tx_en` lasts exactly one slot: it falls at the next strobe unless another grant arrives at that strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_stb | input | 1 | Slot boundary strobe; feedback is sampled and state updates here |
| fb_code | input | 2*NLANE | Per-lane crossbar answer: 00 none, 01 grant, 10 contention loss, 11 backpressure loss |
| cand_valid | input | NLANE | Per-lane selector has an eligible candidate |
| cand_qidx | input | NLANE*QW | Candidate local queue index per lane |
| cand_dest | input | NLANE*DW | Candidate destination per lane |
| cand_prio | input | NLANE*PW | Candidate service priority per lane |
| cand_take | output | NLANE | Candidate accepted this strobe |
| excl_vld | output | NLANE | Queue to be skipped by the next selection |
| excl_idx | output | NLANE*QW | Index of the queue to skip |
| bid_vld | output | NLANE | Bid outstanding toward the crossbar |
| bid_qidx | output | NLANE*QW | Queue index of the outstanding bid |
| bid_dest | output | NLANE*DW | Destination carried by the bid |
| bid_prio | output | NLANE*PW | Priority carried by the bid |
| tx_en | output | NLANE | Transmit the granted cell this slot |
| tx_qidx | output | NLANE*QW | Queue index of the cell to transmit |

## Verification
The assertions assume the crossbar answers only during the strobe cycle of a slot in which a bid is outstanding. They also assume the selector honours the exclusion in that same cycle by offering a queue other than the refused one. The stimulus drives random codes on every cycle, including idle lanes and non-strobe cycles, so that the ignore rules are exercised. When a backpressure answer meets a valid candidate carrying the refused index, the stimulus flips the low bit of that index. The strobe runs both every cycle and at sparse intervals.

// File: rtl/bidctl_pkg.sv
package bidctl_pkg;
  typedef enum logic [1:0] {
    FB_NONE    = 2'b00,
    FB_GRANT   = 2'b01,
    FB_CONTEND = 2'b10,
    FB_BACKPR  = 2'b11
  } fb_code_e;

  typedef enum logic {
    LN_IDLE = 1'b0,
    LN_BID  = 1'b1
  } lane_st_e;
endpackage

// File: rtl/xbar_fb_decode.sv
module xbar_fb_decode
  import bidctl_pkg::*;
(
  input  logic [1:0] code,
  input  logic       armed,
  output logic       won,
  output logic       lost_cont,
  output logic       lost_bp
);
  always_comb begin
    won       = armed && (code == FB_GRANT);
    lost_cont = armed && (code == FB_CONTEND);
    lost_bp   = armed && (code == FB_BACKPR);
  end
endmodule

// File: rtl/bid_lane.sv
module bid_lane
  import bidctl_pkg::*;
#(
  parameter int QW = 6,
  parameter int DW = 6,
  parameter int PW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slot_stb,
  input  logic [1:0]    fb_code,
  input  logic          cand_valid,
  input  logic [QW-1:0] cand_qidx,
  input  logic [DW-1:0] cand_dest,
  input  logic [PW-1:0] cand_prio,
  output logic          cand_take,
  output logic          excl_vld,
  output logic [QW-1:0] excl_idx,
  output logic          bid_vld,
  output logic [QW-1:0] bid_qidx,
  output logic [DW-1:0] bid_dest,
  output logic [PW-1:0] bid_prio,
  output logic          tx_en,
  output logic [QW-1:0] tx_qidx
);
  lane_st_e      st_q, st_d;
  logic [QW-1:0] qidx_q, qidx_d;
  logic [DW-1:0] dest_q, dest_d;
  logic [PW-1:0] prio_q, prio_d;
  logic          tx_q, tx_d;
  logic [QW-1:0] txi_q, txi_d;

  logic won, lost_cont, lost_bp;
  logic fetch, load;

  xbar_fb_decode u_dec (
    .code      (fb_code),
    .armed     (st_q == LN_BID),
    .won       (won),
    .lost_cont (lost_cont),
    .lost_bp   (lost_bp)
  );

  always_comb begin
    fetch  = (st_q == LN_IDLE) || won || lost_bp;
    load   = fetch && cand_valid;
    st_d   = st_q;
    qidx_d = qidx_q;
    dest_d = dest_q;
    prio_d = prio_q;
    tx_d   = won;
    txi_d  = won ? qidx_q : txi_q;
    if (load) begin
      st_d   = LN_BID;
      qidx_d = cand_qidx;
      dest_d = cand_dest;
      prio_d = cand_prio;
    end else if (fetch) begin
      st_d = LN_IDLE;
    end else if (lost_cont) begin
      st_d = LN_BID;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= LN_IDLE;
      qidx_q <= '0;
      dest_q <= '0;
      prio_q <= '0;
      tx_q   <= 1'b0;
      txi_q  <= '0;
    end else if (slot_stb) begin
      st_q   <= st_d;
      qidx_q <= qidx_d;
      dest_q <= dest_d;
      prio_q <= prio_d;
      tx_q   <= tx_d;
      txi_q  <= txi_d;
    end
  end

  assign cand_take = slot_stb && load;
  assign excl_vld  = slot_stb && lost_bp;
  assign excl_idx  = qidx_q;
  assign bid_vld   = (st_q == LN_BID);
  assign bid_qidx  = qidx_q;
  assign bid_dest  = dest_q;
  assign bid_prio  = prio_q;
  assign tx_en     = tx_q;
  assign tx_qidx   = txi_q;
endmodule

// File: rtl/bid_ctrl_top.sv
module bid_ctrl_top #(
  parameter int NLANE = 4,
  parameter int QW    = 6,
  parameter int DW    = 6,
  parameter int PW    = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               slot_stb,
  input  logic [2*NLANE-1:0] fb_code,
  input  logic [NLANE-1:0]   cand_valid,
  input  logic [NLANE*QW-1:0] cand_qidx,
  input  logic [NLANE*DW-1:0] cand_dest,
  input  logic [NLANE*PW-1:0] cand_prio,
  output logic [NLANE-1:0]   cand_take,
  output logic [NLANE-1:0]   excl_vld,
  output logic [NLANE*QW-1:0] excl_idx,
  output logic [NLANE-1:0]   bid_vld,
  output logic [NLANE*QW-1:0] bid_qidx,
  output logic [NLANE*DW-1:0] bid_dest,
  output logic [NLANE*PW-1:0] bid_prio,
  output logic [NLANE-1:0]   tx_en,
  output logic [NLANE*QW-1:0] tx_qidx
);
  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    bid_lane #(.QW(QW), .DW(DW), .PW(PW)) u_lane (
      .clk        (clk),
      .rst_n      (rst_n),
      .slot_stb   (slot_stb),
      .fb_code    (fb_code[2*g +: 2]),
      .cand_valid (cand_valid[g]),
      .cand_qidx  (cand_qidx[g*QW +: QW]),
      .cand_dest  (cand_dest[g*DW +: DW]),
      .cand_prio  (cand_prio[g*PW +: PW]),
      .cand_take  (cand_take[g]),
      .excl_vld   (excl_vld[g]),
      .excl_idx   (excl_idx[g*QW +: QW]),
      .bid_vld    (bid_vld[g]),
      .bid_qidx   (bid_qidx[g*QW +: QW]),
      .bid_dest   (bid_dest[g*DW +: DW]),
      .bid_prio   (bid_prio[g*PW +: PW]),
      .tx_en      (tx_en[g]),
      .tx_qidx    (tx_qidx[g*QW +: QW])
    );
  end
endmodule

// File: rtl/bid_ctrl_chk.sv
module bid_ctrl_chk #(
  parameter int NLANE = 4,
  parameter int QW    = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic                slot_stb,
  input logic [2*NLANE-1:0]  fb_code,
  input logic [NLANE-1:0]    cand_valid,
  input logic [NLANE-1:0]    cand_take,
  input logic [NLANE-1:0]    excl_vld,
  input logic [NLANE*QW-1:0] excl_idx,
  input logic [NLANE-1:0]    bid_vld,
  input logic [NLANE*QW-1:0] bid_qidx,
  input logic [NLANE-1:0]    tx_en,
  input logic [NLANE*QW-1:0] tx_qidx
);
  for (genvar g = 0; g < NLANE; g++) begin : g_chk
    // R2
    quiet_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_stb |=> $stable(bid_vld[g]) && $stable(tx_en[g]) && $stable(bid_qidx[g*QW +: QW]));
    // R3
    take_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cand_take[g] |-> slot_stb && cand_valid[g]);
    // R3
    take_bid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cand_take[g] |=> bid_vld[g]);
    // R5
    grant_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      slot_stb && bid_vld[g] && fb_code[2*g +: 2] == 2'b01
      |=> tx_en[g] && tx_qidx[g*QW +: QW] == $past(bid_qidx[g*QW +: QW]));
    // R6
    contend_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      slot_stb && bid_vld[g] && fb_code[2*g +: 2] == 2'b10
      |=> bid_vld[g] && $stable(bid_qidx[g*QW +: QW]) && !tx_en[g]);
    // R7
    backpr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      slot_stb && bid_vld[g] && fb_code[2*g +: 2] == 2'b11
      |-> excl_vld[g] && excl_idx[g*QW +: QW] == bid_qidx[g*QW +: QW]);
    // R7
    backpr_notx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      slot_stb && bid_vld[g] && fb_code[2*g +: 2] == 2'b11 |=> !tx_en[g]);
    // R7
    excl_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      excl_vld[g] |-> slot_stb && bid_vld[g]);
    // R8
    idle_notx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      slot_stb && !bid_vld[g] |=> !tx_en[g]);
  end
endmodule

bind bid_ctrl_top bid_ctrl_chk #(.NLANE(NLANE), .QW(QW)) u_chk (.*);

// File: tb/sim_bid_ctrl_top.sv
module sim_bid_ctrl_top;
  localparam int NL = 4;
  localparam int QW = 6;
  localparam int DW = 6;
  localparam int PW = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic slot_stb;
  logic [2*NL-1:0]  fb_code;
  logic [NL-1:0]    cand_valid;
  logic [NL*QW-1:0] cand_qidx;
  logic [NL*DW-1:0] cand_dest;
  logic [NL*PW-1:0] cand_prio;
  logic [NL-1:0]    cand_take, excl_vld, bid_vld, tx_en;
  logic [NL*QW-1:0] excl_idx, bid_qidx, tx_qidx;
  logic [NL*DW-1:0] bid_dest;
  logic [NL*PW-1:0] bid_prio;

  always #2 clk = ~clk;

  bid_ctrl_top #(.NLANE(NL), .QW(QW), .DW(DW), .PW(PW)) u0 (.*);

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model state per lane
  int m_bid[NL], m_q[NL], m_d[NL], m_p[NL], m_tx[NL], m_txq[NL];
  string m_tag[NL];
  int n_bid[NL], n_q[NL], n_d[NL], n_p[NL], n_tx[NL], n_txq[NL];
  string n_tag[NL];

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic check_regs();
    for (int l = 0; l < NL; l++) begin
      chk(m_tag[l], "bid_vld", int'(bid_vld[l]), m_bid[l]);
      chk(m_tag[l], "tx_en", int'(tx_en[l]), m_tx[l]);
      if (m_bid[l] != 0) begin
        chk(m_tag[l], "bid_qidx", int'(bid_qidx[l*QW +: QW]), m_q[l]);
        chk(m_tag[l], "bid_dest", int'(bid_dest[l*DW +: DW]), m_d[l]);
        chk(m_tag[l], "bid_prio", int'(bid_prio[l*PW +: PW]), m_p[l]);
      end
      if (m_tx[l] != 0) chk(m_tag[l], "tx_qidx", int'(tx_qidx[l*QW +: QW]), m_txq[l]);
    end
  endtask

  // one clock: check registers, drive, check combinational outputs, advance model
  task automatic step(bit stb, int pvalid);
    @(negedge clk);
    check_regs();
    slot_stb = stb;
    for (int l = 0; l < NL; l++) begin
      int fb = $urandom_range(3);
      int v  = ($urandom_range(99) < pvalid) ? 1 : 0;
      int q  = $urandom_range((1 << QW) - 1);
      if (m_bid[l] != 0 && fb == 3 && q == m_q[l]) q = q ^ 1;
      fb_code[2*l +: 2]     = fb[1:0];
      cand_valid[l]         = v[0];
      cand_qidx[l*QW +: QW] = q[QW-1:0];
      cand_dest[l*DW +: DW] = DW'($urandom);
      cand_prio[l*PW +: PW] = PW'($urandom);
    end
    #1;
    for (int l = 0; l < NL; l++) begin
      int fb = int'(fb_code[2*l +: 2]);
      int v  = int'(cand_valid[l]);
      bit won  = (m_bid[l] != 0) && fb == 1;
      bit cont = (m_bid[l] != 0) && fb == 2;
      bit bp   = (m_bid[l] != 0) && fb == 3;
      bit get  = (m_bid[l] == 0) || won || bp;
      string t;
      if (m_bid[l] == 0) t = (fb != 0) ? "R8" : (v != 0 ? "R3" : "R4");
      else if (won) t = "R5";
      else if (cont) t = "R6";
      else if (bp) t = "R7";
      else t = "R9";
      chk(stb ? (get ? (bp ? "R7" : (won ? "R5" : "R3")) : "R6") : "R2",
          "cand_take", int'(cand_take[l]), (stb && get && v != 0) ? 1 : 0);
      chk(stb ? "R7" : "R2", "excl_vld", int'(excl_vld[l]), (stb && bp) ? 1 : 0);
      if (stb && bp) chk("R7", "excl_idx", int'(excl_idx[l*QW +: QW]), m_q[l]);
      n_bid[l] = m_bid[l]; n_q[l] = m_q[l]; n_d[l] = m_d[l]; n_p[l] = m_p[l];
      n_tx[l] = m_tx[l]; n_txq[l] = m_txq[l]; n_tag[l] = "R2";
      if (stb) begin
        n_tag[l] = (m_tx[l] != 0 && !won) ? "R10" : t;
        n_tx[l] = won ? 1 : 0;
        if (won) n_txq[l] = m_q[l];
        if (get) begin
          if (v != 0) begin
            n_bid[l] = 1;
            n_q[l] = int'(cand_qidx[l*QW +: QW]);
            n_d[l] = int'(cand_dest[l*DW +: DW]);
            n_p[l] = int'(cand_prio[l*PW +: PW]);
          end else n_bid[l] = 0;
        end
      end
    end
    @(posedge clk);
    for (int l = 0; l < NL; l++) begin
      m_bid[l] = n_bid[l]; m_q[l] = n_q[l]; m_d[l] = n_d[l]; m_p[l] = n_p[l];
      m_tx[l] = n_tx[l]; m_txq[l] = n_txq[l]; m_tag[l] = n_tag[l];
    end
  endtask

  initial begin
    rst_n = 1'b0; slot_stb = 1'b0; fb_code = '0; cand_valid = '0;
    cand_qidx = '0; cand_dest = '0; cand_prio = '0;
    for (int l = 0; l < NL; l++) begin
      m_bid[l] = 0; m_q[l] = 0; m_d[l] = 0; m_p[l] = 0; m_tx[l] = 0; m_txq[l] = 0;
      m_tag[l] = "R1";
    end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "bid_vld", int'(bid_vld), 0);
    chk("R1", "tx_en", int'(tx_en), 0);
    chk("R1", "cand_take", int'(cand_take), 0);
    chk("R1", "excl_vld", int'(excl_vld), 0);
    rst_n = 1'b1;
    // empty selector: lanes stay idle (R4)
    for (int i = 0; i < 6; i++) step(1'b1, 0);
    // strobe every cycle, busy selector
    for (int i = 0; i < 1500; i++) step(1'b1, 80);
    // sparse strobe, random feedback between strobes (R2)
    for (int i = 0; i < 1500; i++) step((i % 4) == 3, 60);
    // sparse selector
    for (int i = 0; i < 800; i++) step((i % 2) == 0, 20);
    @(negedge clk);
    check_regs();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule